// File: doc/BRIEF.md
# Access-Aware Row Refresh Scheduler

This block sits beside a DRAM controller and decides which rows really need refreshing. Every row has a small countdown value. A normal read or write to a row reloads that row's value to its maximum. A row is sent for refresh only when its value has run down to zero, which means nothing has touched it for close to a full retention period. Rows that the workload keeps busy are therefore never refreshed at all.

The rows are split into `NUM_SEGS` equal segments. A divider on the core clock makes an update tick. On each tick one shared index selects the same position in every segment, and only those counters move, so a single tick can make at most `NUM_SEGS` rows due. Each due row waits in a slot that belongs to its segment. The slots drain one row at a time through a valid/ready port, and each accepted row is issued by the command engine as a row-strobe-only refresh to that address. At reset the segments start from different counter values, so the first refreshes are spread out in time and do not arrive in one burst.

Top module: `refresh_sched`

## Requirements
- R1: While the active-low reset is low, and right after it is released, `refresh_valid_o` is 0. At reset, every counter in segment s is loaded with MAX - (s mod (MAX+1)), where MAX = 2^CNT_W - 1.
- R2: An update tick happens once every `TICK_DIV` clock cycles. The first tick falls on the `TICK_DIV`-th rising edge after reset is released. Each tick advances the shared index by one, wrapping from SEG_LEN-1 back to 0, with SEG_LEN = NUM_ROWS/NUM_SEGS. In segment s the index selects row s*SEG_LEN + index.
- R3: On a tick, each selected counter that is not zero drops by one. Each selected counter that is zero reloads to MAX, and its row becomes pending in the slot of its segment.
- R4: An access reloads the accessed row's counter to MAX on the next edge. When an access and a tick hit the same counter in the same cycle, the access wins: the counter reloads and no refresh is queued.
- R5: An access to a row that is already pending does not cancel its refresh. The row is still presented and issued.
- R6: `refresh_valid_o` is 1 while any slot is pending. When the port did not stall on the previous cycle, the presented row is the pending row of the lowest-numbered segment. While valid is high and ready is low, the same row stays presented. A transfer (valid and ready both high) clears that slot.
- R7: Each segment holds at most one pending row. A tick that makes a segment's row due while that segment's slot is still occupied and not being drained is an overflow, which the design must never reach.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| access_valid_i | input | 1 | A normal access touched a row this cycle |
| access_row_i | input | ROW_W | Row address of that access |
| refresh_valid_o | output | 1 | A row is waiting for refresh |
| refresh_row_o | output | ROW_W | Row address to refresh with the row strobe alone |
| refresh_ready_i | input | 1 | Command side accepts the presented row |

## Verification
A wrong counter or index shows at the ports only when that row comes up again. A refresh then appears one or more passes too early or too late, or a busy row that should never be refreshed is issued. Such a fault can stay hidden for up to (MAX+1)*SEG_LEN ticks. For this reason the bench compares the port against a behavioural model on every cycle over several whole refresh periods. A wrong slot or priority state shows much sooner, as a wrong row or a wrong valid level within the same tick window.

// File: rtl/refresh_pkg.sv
package refresh_pkg;
  // start value for a segment so the segments expire on different passes
  function automatic int unsigned stagger_init(int unsigned seg, int unsigned cmax);
    return cmax - (seg % (cmax + 1));
  endfunction
endpackage

// File: rtl/refresh_tick.sv
module refresh_tick #(
  parameter int unsigned TICK_DIV = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic [DIV_W-1:0] div_q;

  assign tick_o = (div_q == DIV_W'(TICK_DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     div_q <= '0;
    else if (tick_o) div_q <= '0;
    else             div_q <= div_q + 1'b1;
  end

  // R2
  tick_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/refresh_counters.sv
module refresh_counters
  import refresh_pkg::*;
#(
  parameter int unsigned NUM_ROWS = 64,
  parameter int unsigned NUM_SEGS = 4,
  parameter int unsigned CNT_W    = 2,
  localparam int unsigned ROW_W   = $clog2(NUM_ROWS),
  localparam int unsigned SEG_LEN = NUM_ROWS / NUM_SEGS,
  localparam int unsigned IDX_W   = (SEG_LEN > 1) ? $clog2(SEG_LEN) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             acc_valid_i,
  input  logic [ROW_W-1:0] acc_row_i,
  output logic             expire_o [NUM_SEGS],
  output logic [ROW_W-1:0] seg_row_o [NUM_SEGS]
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q [NUM_ROWS];
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      idx_q <= '0;
    else if (tick_i)
      idx_q <= (idx_q == IDX_W'(SEG_LEN - 1)) ? '0 : idx_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 0; r < NUM_ROWS; r++)
        cnt_q[r] <= CNT_W'(stagger_init(r / SEG_LEN, CNT_MAX));
    end else begin
      for (int r = 0; r < NUM_ROWS; r++) begin
        if (acc_valid_i && acc_row_i == ROW_W'(r))
          cnt_q[r] <= CNT_MAX;  // access beats tick
        else if (tick_i && idx_q == IDX_W'(r % SEG_LEN))
          cnt_q[r] <= (cnt_q[r] == '0) ? CNT_MAX : cnt_q[r] - 1'b1;
      end
    end
  end

  for (genvar s = 0; s < NUM_SEGS; s++) begin : g_seg
    assign seg_row_o[s] = ROW_W'(s * SEG_LEN) + ROW_W'(idx_q);
    assign expire_o[s]  = tick_i && (cnt_q[seg_row_o[s]] == '0) &&
                          !(acc_valid_i && acc_row_i == seg_row_o[s]);
  end

  // R4
  acc_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i |=> cnt_q[$past(acc_row_i)] == CNT_MAX);
  // R2
  idx_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && idx_q == IDX_W'(SEG_LEN - 1)) |=> idx_q == '0);
  // R2
  idx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(idx_q));
endmodule

// File: rtl/refresh_slots.sv
module refresh_slots #(
  parameter int unsigned NUM_SEGS = 4,
  parameter int unsigned ROW_W    = 6,
  localparam int unsigned SEG_W   = (NUM_SEGS > 1) ? $clog2(NUM_SEGS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             expire_i [NUM_SEGS],
  input  logic [ROW_W-1:0] seg_row_i [NUM_SEGS],
  output logic             valid_o,
  output logic [ROW_W-1:0] row_o,
  input  logic             ready_i
);
  logic [NUM_SEGS-1:0] vld_q;
  logic [ROW_W-1:0]    row_q [NUM_SEGS];
  logic                hold_q;
  logic [SEG_W-1:0]    hold_seg_q;
  logic [SEG_W-1:0]    low_seg, cur_seg;
  logic                pop;

  always_comb begin
    low_seg = '0;
    for (int s = NUM_SEGS - 1; s >= 0; s--)
      if (vld_q[s]) low_seg = SEG_W'(s);
  end

  // keep the presented row fixed while the port stalls
  assign cur_seg = hold_q ? hold_seg_q : low_seg;
  assign valid_o = |vld_q;
  assign row_o   = row_q[cur_seg];
  assign pop     = valid_o && ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q     <= 1'b0;
      hold_seg_q <= '0;
    end else begin
      hold_q     <= valid_o && !ready_i;
      hold_seg_q <= cur_seg;
    end
  end

  for (genvar s = 0; s < NUM_SEGS; s++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[s] <= 1'b0;
        row_q[s] <= '0;
      end else if (expire_i[s]) begin
        vld_q[s] <= 1'b1;
        row_q[s] <= seg_row_i[s];
      end else if (pop && cur_seg == SEG_W'(s)) begin
        vld_q[s] <= 1'b0;
      end
    end

    // R7
    no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (expire_i[s] && vld_q[s]) |-> (pop && cur_seg == SEG_W'(s)));
  end

  // R6
  row_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |=> (valid_o && $stable(row_o)));
endmodule

// File: rtl/refresh_sched.sv
module refresh_sched #(
  parameter int unsigned NUM_ROWS = 64,
  parameter int unsigned NUM_SEGS = 4,
  parameter int unsigned CNT_W    = 2,
  parameter int unsigned TICK_DIV = 16,
  localparam int unsigned ROW_W   = $clog2(NUM_ROWS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             access_valid_i,
  input  logic [ROW_W-1:0] access_row_i,
  output logic             refresh_valid_o,
  output logic [ROW_W-1:0] refresh_row_o,
  input  logic             refresh_ready_i
);
  logic             tick;
  logic             expire  [NUM_SEGS];
  logic [ROW_W-1:0] seg_row [NUM_SEGS];

  initial begin
    seg_split_chk: assert (NUM_ROWS % NUM_SEGS == 0 && TICK_DIV >= NUM_SEGS);
  end

  refresh_tick #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  refresh_counters #(
    .NUM_ROWS (NUM_ROWS),
    .NUM_SEGS (NUM_SEGS),
    .CNT_W    (CNT_W)
  ) u_counters (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick),
    .acc_valid_i (access_valid_i),
    .acc_row_i   (access_row_i),
    .expire_o    (expire),
    .seg_row_o   (seg_row)
  );

  refresh_slots #(
    .NUM_SEGS (NUM_SEGS),
    .ROW_W    (ROW_W)
  ) u_slots (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .expire_i  (expire),
    .seg_row_i (seg_row),
    .valid_o   (refresh_valid_o),
    .row_o     (refresh_row_o),
    .ready_i   (refresh_ready_i)
  );

  // R1
  reset_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !refresh_valid_o);
endmodule

// File: tb/refresh_sched_bench.sv
module refresh_sched_bench;
  localparam int NUM_ROWS = 64;
  localparam int NUM_SEGS = 4;
  localparam int CNT_W    = 2;
  localparam int TICK_DIV = 16;
  localparam int ROW_W    = $clog2(NUM_ROWS);
  localparam int SEG_LEN  = NUM_ROWS / NUM_SEGS;
  localparam int CMAX     = (1 << CNT_W) - 1;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             acc_v = 1'b0;
  logic [ROW_W-1:0] acc_r = '0;
  logic             rdy = 1'b0;
  logic             rv;
  logic [ROW_W-1:0] rr;

  int checks = 0;
  int fails  = 0;

  // behavioural model state
  int m_cnt [NUM_ROWS];
  int m_pend [NUM_SEGS];
  int m_prow [NUM_SEGS];
  int m_div, m_idx, m_hold, m_hseg;

  always #2 clk = ~clk;

  refresh_sched #(
    .NUM_ROWS (NUM_ROWS),
    .NUM_SEGS (NUM_SEGS),
    .CNT_W    (CNT_W),
    .TICK_DIV (TICK_DIV)
  ) u_refresh_sched (
    .clk_i           (clk),
    .rst_ni          (rst_n),
    .access_valid_i  (acc_v),
    .access_row_i    (acc_r),
    .refresh_valid_o (rv),
    .refresh_row_o   (rr),
    .refresh_ready_i (rdy)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int r = 0; r < NUM_ROWS; r++) m_cnt[r] = CMAX - ((r / SEG_LEN) % (CMAX + 1));
    for (int s = 0; s < NUM_SEGS; s++) begin m_pend[s] = 0; m_prow[s] = 0; end
    m_div = 0; m_idx = 0; m_hold = 0; m_hseg = 0;
  endtask

  function automatic int m_valid();
    for (int s = 0; s < NUM_SEGS; s++) if (m_pend[s] != 0) return 1;
    return 0;
  endfunction

  function automatic int m_seg();
    if (m_hold != 0) return m_hseg;
    for (int s = 0; s < NUM_SEGS; s++) if (m_pend[s] != 0) return s;
    return 0;
  endfunction

  function automatic int m_tick_now();
    return (m_div == TICK_DIV - 1) ? 1 : 0;
  endfunction

  // called just after a falling edge: compare, drive, advance model, wait one cycle
  task automatic step(input logic av, input int ar, input logic rd, input string tag);
    int v, sg, tk;
    v  = m_valid();
    sg = m_seg();
    check({tag, " valid"}, int'(rv), v);
    if (v != 0) check({tag, " row"}, int'(rr), m_prow[sg]);
    acc_v = av; acc_r = ROW_W'(ar); rdy = rd;
    // model next state
    if (v != 0 && rd) m_pend[sg] = 0;
    m_hold = (v != 0 && !rd) ? 1 : 0;
    m_hseg = sg;
    tk = m_tick_now();
    m_div = (tk != 0) ? 0 : m_div + 1;
    if (tk != 0) begin
      for (int s = 0; s < NUM_SEGS; s++) begin
        int r;
        r = s * SEG_LEN + m_idx;
        if (!(av && ar == r)) begin
          if (m_cnt[r] == 0) begin
            m_pend[s] = 1; m_prow[s] = r; m_cnt[r] = CMAX;
          end else m_cnt[r] = m_cnt[r] - 1;
        end
      end
      m_idx = (m_idx + 1) % SEG_LEN;
    end
    if (av) m_cnt[ar] = CMAX;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    logic [15:0] lfsr;
    int busy_hits, held_row;
    lfsr = 16'hACE1;
    model_reset();
    repeat (3) @(negedge clk);
    check("R1 valid in reset", int'(rv), 0);
    rst_n = 1'b1;
    check("R1 valid after release", int'(rv), 0);

    // idle: staggered start, periodic expiry, full drain (R1 R2 R3)
    for (int i = 0; i < 2600; i++) step(1'b0, 0, 1'b1, "R3 idle");

    // random accesses with a 3/4 ready pattern (R4 R6)
    for (int i = 0; i < 2600; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0] & lfsr[5], int'(lfsr[11:6]), (i % 4) != 0, "R6 random");
    end

    // access landing on a tick-selected counter in the same cycle (R4)
    for (int n = 0; n < 40; n++) begin
      while (m_tick_now() == 0) step(1'b0, 0, 1'b1, "R2 wait tick");
      step(1'b1, (NUM_SEGS - 1) * SEG_LEN + m_idx, 1'b1, "R4 same cycle");
    end

    // a row accessed every cycle is never refreshed (R4)
    busy_hits = 0;
    for (int i = 0; i < 2200; i++) begin
      if (rv && rr == ROW_W'(5)) busy_hits++;
      step(1'b1, 5, 1'b1, "R4 busy row");
    end
    check("R4 busy row refresh count", busy_hits, 0);

    // access to a pending row does not cancel it; stalled row holds (R5 R6)
    for (int n = 0; n < 6; n++) begin
      while (m_valid() == 0) step(1'b0, 0, 1'b0, "R5 wait pending");
      held_row = int'(rr);
      step(1'b1, held_row, 1'b0, "R5 access pending row");
      check("R5 still valid", int'(rv), 1);
      check("R6 row held", int'(rr), held_row);
      step(1'b0, 0, 1'b1, "R5 issue");
    end

    for (int i = 0; i < 600; i++) step(1'b0, 0, 1'b1, "R3 tail");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule